// File: doc/BRIEF.md
# Selectable-Tap Single-Cycle FIR Multiply-Accumulate Unit

This block produces one finite impulse response filter output for each accepted input sample. A shift register holds the most recent samples. The block stores each incoming signed sample as a sign bit and a magnitude. It multiplies every stored sample by its own coefficient, using one multiplier per tap, and all multipliers work in parallel. A single summing stage then adds all products in the same cycle, so the output needs only one multiplier delay plus the sum. The unit has its own datapath and does not use a general-purpose ALU.

The tap count is chosen at run time. In long mode, all eight taps are used. In short mode, the products of the upper four taps are forced to zero, so those taps add nothing. Coefficients are written one at a time through an index-plus-data port. The block holds its output back until enough samples have arrived to fill the active window. Changing the mode discards the history, and filling starts again.

Top module: `fir_mac_unit`

## Requirements
- R1: After reset, `res_vld` is 0, `res_out` is 0, every coefficient is 0, and the sample history is empty.
- R2: When `cf_we` is 1, `cf_data` is written into coefficient `cf_idx` at the clock edge. Coefficient 0 multiplies the newest sample. Coefficient k multiplies the sample taken k accepted samples earlier.
- R3: A sample is accepted when `smp_vld` is 1 and the mode is not changing. Once the window is full, `res_vld` is 1 in the cycle after the accepted sample. In that same cycle, `res_out` holds the full-precision two's-complement sum of coefficient×sample over the active taps, 35 bits wide. The window includes the sample just accepted.
- R4: In long mode (`tap_sel`=1), the first 7 accepted samples after a clear give no `res_vld`. In short mode (`tap_sel`=0), the first 3 give none.
- R5: In short mode, coefficients 4 to 7 and the older samples they would multiply do not affect `res_out`.
- R6: A mode change is a cycle in which `tap_sel` differs from its value in the previous cycle. The mode register resets to long mode. A mode change clears the history and the fill count, and a sample presented in that cycle is dropped.
- R7: The input sample -32768 is treated as -32767, because the magnitude is limited to 15 bits. All other values are used exactly.
- R8: Suppose a coefficient write and an accepted sample fall in the same cycle. The result for that sample uses the old coefficient value, and later samples use the new one.
- R9: In any cycle after which no result is produced, `res_vld` is 0 and `res_out` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | 16 | Signed input sample |
| smp_vld | input | 1 | Sample strobe |
| cf_we | input | 1 | Coefficient write strobe |
| cf_idx | input | 3 | Coefficient index |
| cf_data | input | 16 | Signed coefficient value |
| tap_sel | input | 1 | 1 = eight taps, 0 = four taps |
| res_out | output | 35 | Signed filter result |
| res_vld | output | 1 | Result strobe |

## Verification
A coefficient write can land in the same cycle as an accepted sample. A mode change can also coincide with a sample strobe. The random stream sets the write strobe and the mode toggle independently of the sample strobe, so both collisions happen often. Directed steps also force each collision once. The bench model applies the write after it computes that cycle's result, and it drops any sample that arrives with a mode change. A wrong ordering in the design therefore shows up as a mismatch in the result value or in the valid strobe.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
   typedef enum logic {
      TAPS_SHORT = 1'b0,
      TAPS_LONG  = 1'b1
   } tap_mode_e;
endpackage

// File: rtl/fir_sample_conv.sv
module fir_sample_conv #(
   parameter int SMP_W = 16
) (
   input  logic signed [SMP_W-1:0] din,
   output logic                    sgn,
   output logic [SMP_W-2:0]        mag
);
   localparam logic signed [SMP_W-1:0] MOST_NEG = {1'b1, {(SMP_W-1){1'b0}}};

   logic signed [SMP_W-1:0] absval;

   always_comb begin
      sgn    = din[SMP_W-1];
      absval = sgn ? -din : din;
      if (din == MOST_NEG) mag = {(SMP_W-1){1'b1}};
      else                 mag = absval[SMP_W-2:0];
   end
endmodule

// File: rtl/fir_tap_mult.sv
module fir_tap_mult #(
   parameter int MAG_W  = 15,
   parameter int COEF_W = 16,
   parameter bit GATED  = 1'b0,
   localparam int PROD_W = MAG_W + COEF_W + 1
) (
   input  logic                     sgn,
   input  logic [MAG_W-1:0]         mag,
   input  logic signed [COEF_W-1:0] coef,
   input  logic                     short_mode,
   output logic signed [PROD_W-1:0] prod
);
   logic [MAG_W-1:0]        eff_mag;
   logic [COEF_W-1:0]       cmag;
   logic [MAG_W+COEF_W-1:0] umag;
   logic                    neg;

   generate
      if (GATED) begin : g_zero_mux
         assign eff_mag = short_mode ? '0 : mag;
      end else begin : g_direct
         assign eff_mag = mag;
      end
   endgenerate

   always_comb begin
      cmag = coef[COEF_W-1] ? COEF_W'(-coef) : COEF_W'(coef);
      umag = MAG_W'(eff_mag) * cmag;
      neg  = sgn ^ coef[COEF_W-1];
      prod = neg ? -$signed({1'b0, umag}) : $signed({1'b0, umag});
   end
endmodule

// File: rtl/fir_product_sum.sv
module fir_product_sum #(
   parameter int N     = 8,
   parameter int IN_W  = 32,
   parameter int OUT_W = 35
) (
   input  logic signed [IN_W-1:0]  terms [N],
   output logic signed [OUT_W-1:0] total
);
   always_comb begin
      total = '0;
      for (int k = 0; k < N; k++) total += OUT_W'(terms[k]);
   end
endmodule

// File: rtl/fir_mac_unit.sv
module fir_mac_unit #(
   parameter int SMP_W      = 16,
   parameter int COEF_W     = 16,
   parameter int NUM_TAPS   = 8,
   parameter int SHORT_TAPS = 4,
   localparam int MAG_W  = SMP_W - 1,
   localparam int PROD_W = MAG_W + COEF_W + 1,
   localparam int IDX_W  = $clog2(NUM_TAPS),
   localparam int CNT_W  = $clog2(NUM_TAPS + 1),
   localparam int ACC_W  = SMP_W + COEF_W + IDX_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [SMP_W-1:0]  smp_in,
   input  logic                     smp_vld,
   input  logic                     cf_we,
   input  logic [IDX_W-1:0]         cf_idx,
   input  logic signed [COEF_W-1:0] cf_data,
   input  logic                     tap_sel,
   output logic signed [ACC_W-1:0]  res_out,
   output logic                     res_vld
);
   import fir_mac_pkg::*;

   generate
      if (SHORT_TAPS < 1 || SHORT_TAPS > NUM_TAPS) begin : g_bad_short
         $error("SHORT_TAPS must lie in 1..NUM_TAPS");
      end
      if (NUM_TAPS < 2 || SMP_W < 2) begin : g_bad_size
         $error("NUM_TAPS and SMP_W must be at least 2");
      end
   endgenerate

   tap_mode_e               mode_q;
   logic [CNT_W-1:0]        fill_cnt, fill_nxt, taps_act;
   logic                    sr_sgn [NUM_TAPS];
   logic [MAG_W-1:0]        sr_mag [NUM_TAPS];
   logic                    win_sgn [NUM_TAPS];
   logic [MAG_W-1:0]        win_mag [NUM_TAPS];
   logic signed [COEF_W-1:0] coef_q [NUM_TAPS];
   logic signed [PROD_W-1:0] prods [NUM_TAPS];
   logic signed [ACC_W-1:0]  sum_c;
   logic                    new_sgn;
   logic [MAG_W-1:0]        new_mag;
   logic                    mode_chg, accept, fire, short_mode;

   fir_sample_conv #(.SMP_W(SMP_W)) u_conv (
      .din(smp_in), .sgn(new_sgn), .mag(new_mag)
   );

   always_comb begin
      short_mode = (mode_q == TAPS_SHORT);
      taps_act   = short_mode ? CNT_W'(SHORT_TAPS) : CNT_W'(NUM_TAPS);
      mode_chg   = (tap_sel != logic'(mode_q));
      accept     = smp_vld && !mode_chg;
      fill_nxt   = (fill_cnt == taps_act) ? fill_cnt : fill_cnt + 1'b1;
      fire       = accept && (fill_nxt == taps_act);
      win_sgn[0] = new_sgn;
      win_mag[0] = new_mag;
      for (int k = 1; k < NUM_TAPS; k++) begin
         win_sgn[k] = sr_sgn[k-1];
         win_mag[k] = sr_mag[k-1];
      end
   end

   generate
      for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
         fir_tap_mult #(
            .MAG_W(MAG_W), .COEF_W(COEF_W), .GATED(t >= SHORT_TAPS)
         ) u_mult (
            .sgn(win_sgn[t]), .mag(win_mag[t]), .coef(coef_q[t]),
            .short_mode(short_mode), .prod(prods[t])
         );
      end
   endgenerate

   fir_product_sum #(.N(NUM_TAPS), .IN_W(PROD_W), .OUT_W(ACC_W)) u_sum (
      .terms(prods), .total(sum_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= TAPS_LONG;
         fill_cnt <= '0;
         res_vld  <= 1'b0;
         res_out  <= '0;
         for (int k = 0; k < NUM_TAPS; k++) begin
            sr_sgn[k] <= 1'b0;
            sr_mag[k] <= '0;
            coef_q[k] <= '0;
         end
      end else begin
         mode_q  <= tap_mode_e'(tap_sel);
         res_vld <= fire;
         if (fire) res_out <= sum_c;
         if (cf_we) coef_q[cf_idx] <= cf_data;
         if (mode_chg) begin
            fill_cnt <= '0;
            for (int k = 0; k < NUM_TAPS; k++) begin
               sr_sgn[k] <= 1'b0;
               sr_mag[k] <= '0;
            end
         end else if (accept) begin
            fill_cnt <= fill_nxt;
            for (int k = 0; k < NUM_TAPS; k++) begin
               sr_sgn[k] <= win_sgn[k];
               sr_mag[k] <= win_mag[k];
            end
         end
      end
   end

   // R3
   vld_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> $past(smp_vld));

   // R4
   full_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_vld |-> (fill_cnt == taps_act));

   // R6
   mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |=> (fill_cnt == '0 && !res_vld));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(res_out));
endmodule

// File: tb/fir_mac_unit_tb.sv
`timescale 1ns/1ps
module fir_mac_unit_tb;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic signed [15:0] smp_in = '0;
   logic               smp_vld = 1'b0;
   logic               cf_we = 1'b0;
   logic [2:0]         cf_idx = '0;
   logic signed [15:0] cf_data = '0;
   logic               tap_sel = 1'b1;
   logic signed [34:0] res_out;
   logic               res_vld;

   fir_mac_unit u_dut (
      .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
      .cf_we(cf_we), .cf_idx(cf_idx), .cf_data(cf_data), .tap_sel(tap_sel),
      .res_out(res_out), .res_vld(res_vld)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   longint m_coef [8];
   longint m_hist [8];
   int     m_fill;
   bit     m_mode;
   bit     e_vld;
   longint e_out;
   int     dummy_seed;

   function automatic longint conv(input logic signed [15:0] s);
      return (s == -16'sd32768) ? -64'sd32767 : longint'(s);
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int k = 0; k < 8; k++) begin m_coef[k] = 0; m_hist[k] = 0; end
      m_fill = 0; m_mode = 1'b1; e_vld = 1'b0; e_out = 0;
   endtask

   // one cycle: drive at negedge, update model, check at following negedge
   task automatic cyc(input bit vld, input logic signed [15:0] s, input bit we,
                      input int idx, input logic signed [15:0] cd, input bit sel,
                      input string tag);
      int taps;
      longint acc;
      smp_vld = vld; smp_in = s; cf_we = we; cf_idx = 3'(idx);
      cf_data = cd; tap_sel = sel;
      e_vld = 1'b0;
      if (sel != m_mode) begin
         for (int k = 0; k < 8; k++) m_hist[k] = 0;
         m_fill = 0; m_mode = sel;
      end else if (vld) begin
         taps = m_mode ? 8 : 4;
         for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
         m_hist[0] = conv(s);
         if (m_fill < taps) m_fill++;
         if (m_fill == taps) begin
            acc = 0;
            for (int k = 0; k < taps; k++) acc += m_coef[k] * m_hist[k];
            e_vld = 1'b1; e_out = acc;
         end
      end
      if (we) m_coef[idx] = longint'(cd);
      @(negedge clk);
      chk({tag, " vld"}, longint'(res_vld), longint'(e_vld));
      chk({tag, " out"}, longint'(res_out), e_out);
   endtask

   initial begin
      #(5.0 * 150000);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      dummy_seed = $urandom(32'd1234);
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 vld", longint'(res_vld), 0);
      chk("R1 out", longint'(res_out), 0);
      rst_n = 1'b1;
      // R1 zero coefficients: full window gives 0; R4 no valid before fill
      for (int i = 0; i < 8; i++) cyc(1, 16'(1000 + i), 0, 0, 0, 1, "R1_R4");
      // R2 load coefficients
      for (int i = 0; i < 8; i++) cyc(0, 0, 1, i, 16'(i + 1), 1, "R2");
      // R3 main function, long mode
      for (int i = 0; i < 10; i++) cyc(1, 16'(i * 37 - 100), 0, 0, 0, 1, "R3");
      // R7 most negative sample and max coefficient magnitude
      for (int i = 0; i < 8; i++) cyc(0, 0, 1, i, -16'sd32768, 1, "R7");
      for (int i = 0; i < 9; i++) cyc(1, -16'sd32768, 0, 0, 0, 1, "R7");
      cyc(1, 16'sd32767, 0, 0, 0, 1, "R7");
      // R6 mode change with sample dropped, R5 short mode, R4 short fill
      cyc(1, 16'sd500, 0, 0, 0, 0, "R6");
      for (int i = 0; i < 3; i++) cyc(1, 16'(i + 7), 0, 0, 0, 0, "R4");
      for (int i = 0; i < 6; i++) cyc(1, 16'(-i * 911), 1, 4 + (i % 4), 16'(1234 * i), 0, "R5");
      // R8 write colliding with sample
      cyc(1, 16'sd3000, 1, 0, 16'sd77, 0, "R8");
      cyc(1, 16'sd3000, 0, 0, 0, 0, "R8");
      // R6 back to long, mid-fill change
      cyc(1, 16'sd9, 0, 0, 0, 1, "R6");
      for (int i = 0; i < 5; i++) cyc(1, 16'(i), 0, 0, 0, 1, "R6");
      cyc(0, 0, 0, 0, 0, 0, "R6");
      cyc(0, 0, 0, 0, 0, 1, "R6");
      for (int i = 0; i < 8; i++) cyc(1, 16'(50 * i), 0, 0, 0, 1, "R4");
      // R9 idle cycles hold result
      for (int i = 0; i < 4; i++) cyc(0, 16'sd1, 0, 0, 0, 1, "R9");
      // random mix
      begin
         bit sel = 1'b1;
         for (int i = 0; i < 4000; i++) begin
            bit v = ($urandom % 4) != 0;
            bit w = ($urandom % 6) == 0;
            if (($urandom % 60) == 0) sel = ~sel;
            cyc(v, 16'($urandom), w, int'($urandom % 8), 16'($urandom), sel,
                "R3_R8_rand");
         end
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule